// File: doc/BRIEF.md
# Back-End Stall Cause Counters

This block sorts the cycles a core loses in its back end by what caused them. A cycle becomes chargeable only when dispatch is blocked because the reorder buffer has no free entry. In such a cycle the block looks at the status of the oldest instruction in the buffer and adds the cycle to exactly one cause counter. The possible causes are a data TLB miss, a data miss in the second-level cache, a data miss in the first-level cache, or a long-latency functional unit such as a divider. A stall cycle with none of these flags set goes to an "other" counter.

A free-running total cycle counter runs next to the cause counters, so that software can relate stall cycles to elapsed time. All counters saturate at their largest value instead of wrapping. A synchronous clear resets every counter at once. A select input picks one counter, and its value is shown combinationally on the read port. The logic that produces the head status flags sits outside this block.

Top module: `stall_charge_counters`

## Requirements
- R1: After a synchronous reset, every counter reads 0 on `rd_data`.
- R2: The total counter (select 0) rises by one on every clock edge where `clear` is low, whether or not a stall is present.
- R3: The cause counters (selects 1 to 5) do not change on an edge where `rob_full_stall` is low, whatever the head status flags are.
- R4: On an edge where `rob_full_stall` is high and `clear` is low, exactly one cause counter rises by one, unless that counter is already saturated.
- R5: When more than one head flag is set during a stall, the cycle is charged by fixed priority: data TLB miss (select 1), then L2 data miss (select 2), then L1 data miss (select 3), then long functional unit (select 4).
- R6: A stall cycle with no head flag set is charged to the other counter (select 5).
- R7: On an edge where `clear` is high, all counters become 0, including when a stall would have charged that cycle.
- R8: A counter that holds its all-ones value stays there when it would be incremented.
- R9: `rd_data` shows the counter picked by `rd_sel` in the same cycle, using these codes: 0 total, 1 data TLB, 2 L2 data, 3 L1 data, 4 long unit, 5 other. Codes 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rob_full_stall | input | 1 | Dispatch is blocked because the reorder buffer is full |
| head_dtlb_miss | input | 1 | Oldest instruction waits on a data TLB miss |
| head_l2_miss | input | 1 | Oldest instruction waits on an L2 data miss |
| head_l1_miss | input | 1 | Oldest instruction waits on an L1 data miss |
| head_long_fu | input | 1 | Oldest instruction occupies a long-latency unit |
| clear | input | 1 | Synchronous clear of all counters |
| rd_sel | input | 3 | Counter select for read-out |
| rd_data | output | CNT_W | Value of the selected counter |

## Verification
A fault in the cause selection shows up as a count in the wrong cause counter, or as two counters moving for one stall cycle. It becomes visible on the read port on the first clock edge after the stall cycle. A broken saturation shows as a value that wraps to a small number one edge after the counter reached all ones. A broken clear shows as a non-zero read on the first edge after clear. Because reads are combinational, each such state can be read in the cycle right after it forms, and the bench compares every read with a model that is built from the requirements alone.

// File: rtl/stall_cnt_pkg.sv
// Shared constants and types for the back-end stall cause counters.
// Assumes the counter index order below is the read-select encoding.
package stall_cnt_pkg;
    localparam int NUM_CTR = 6;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        CTR_TOTAL  = 3'd0,
        CTR_DTLB   = 3'd1,
        CTR_L2     = 3'd2,
        CTR_L1     = 3'd3,
        CTR_LONGFU = 3'd4,
        CTR_OTHER  = 3'd5
    } ctr_id_e;

    typedef struct packed {
        logic dtlb;
        logic l2;
        logic l1;
        logic long_fu;
    } head_status_t;
endpackage

// File: rtl/stall_cause_pick.sv
// Turns the stall flag and head status into a per-counter increment vector.
// Bit CTR_TOTAL is always set; during a stall exactly one cause bit is set,
// chosen by fixed priority data TLB > L2 > L1 > long unit > other.
module stall_cause_pick
    import stall_cnt_pkg::*;
(
    input  logic               stall,
    input  head_status_t       st,
    output logic [NUM_CTR-1:0] bump
);
    // Priority selection of the one cause charged this cycle.
    always_comb begin
        bump            = '0;
        bump[CTR_TOTAL] = 1'b1;
        if (stall) begin
            if (st.dtlb)         bump[CTR_DTLB]   = 1'b1;
            else if (st.l2)      bump[CTR_L2]     = 1'b1;
            else if (st.l1)      bump[CTR_L1]     = 1'b1;
            else if (st.long_fu) bump[CTR_LONGFU] = 1'b1;
            else                 bump[CTR_OTHER]  = 1'b1;
        end
    end
endmodule

// File: rtl/sat_counter.sv
// Saturating up-counter with synchronous clear that wins over increment.
// Assumes synchronous active-low reset.
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Count state: reset, clear, or saturating increment.
    always_ff @(posedge clk) begin
        if (!rst_n)                  q <= '0;
        else if (clr)                q <= '0;
        else if (inc && q != MAXV)   q <= q + 1'b1;
    end
endmodule

// File: rtl/stall_charge_counters.sv
// Top: charges reorder-buffer-full stall cycles to the cause at the head,
// keeps a total cycle count, and offers a combinational read-out by select.
// Assumes head status flags are valid in the same cycle as the stall flag.
module stall_charge_counters
    import stall_cnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rob_full_stall,
    input  logic              head_dtlb_miss,
    input  logic              head_l2_miss,
    input  logic              head_l1_miss,
    input  logic              head_long_fu,
    input  logic              clear,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [CNT_W-1:0]  rd_data
);
    head_status_t             st;
    logic [NUM_CTR-1:0]       bump;
    logic [CNT_W-1:0]         ctr_q [NUM_CTR];
    logic [NUM_CTR*CNT_W-1:0] ctr_flat;

    // Gather head status into one struct.
    always_comb begin
        st.dtlb    = head_dtlb_miss;
        st.l2      = head_l2_miss;
        st.l1      = head_l1_miss;
        st.long_fu = head_long_fu;
    end

    stall_cause_pick u_pick (
        .stall (rob_full_stall),
        .st    (st),
        .bump  (bump)
    );

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clear),
            .inc   (bump[i]),
            .q     (ctr_q[i])
        );
        assign ctr_flat[i*CNT_W +: CNT_W] = ctr_q[i];
    end

    // Read-out multiplexer; unused select codes read zero.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_CTR; k++) begin
            if (int'(rd_sel) == k) rd_data = ctr_q[k];
        end
    end
endmodule

// File: rtl/stall_charge_counters_chk.sv
// Checker for stall_charge_counters, attached by bind. Watches the inputs
// and the packed counter state and checks the charging rules over time.
module stall_charge_counters_chk
    import stall_cnt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rob_full_stall,
    input logic                     head_dtlb_miss,
    input logic                     head_l2_miss,
    input logic                     head_l1_miss,
    input logic                     head_long_fu,
    input logic                     clear,
    input logic [NUM_CTR*CNT_W-1:0] ctr_flat
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W-1:0]         c_total, c_dtlb, c_other;
    logic [NUM_CTR*CNT_W-1:0] prev;
    logic [NUM_CTR-1:0]       changed;
    logic                     no_flag;

    assign c_total = ctr_flat[0*CNT_W +: CNT_W];
    assign c_dtlb  = ctr_flat[1*CNT_W +: CNT_W];
    assign c_other = ctr_flat[5*CNT_W +: CNT_W];
    assign no_flag = !head_dtlb_miss && !head_l2_miss && !head_l1_miss && !head_long_fu;

    // Previous counter state, for per-counter change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= ctr_flat;
    end

    // Which cause counters moved on the last edge.
    always_comb begin
        changed = '0;
        for (int k = 1; k < NUM_CTR; k++)
            changed[k] = ctr_flat[k*CNT_W +: CNT_W] != prev[k*CNT_W +: CNT_W];
    end

    assert_total_counts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && c_total != MAXV) |=> c_total == $past(c_total) + 1'b1);

    assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rob_full_stall && !clear) |=> $stable(ctr_flat[NUM_CTR*CNT_W-1:CNT_W]));

    assert_one_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rob_full_stall && !clear) |=> $countones(changed) <= 1);

    assert_dtlb_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rob_full_stall && head_dtlb_miss && !clear && c_dtlb != MAXV)
        |=> c_dtlb == $past(c_dtlb) + 1'b1);

    assert_other_bucket_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rob_full_stall && no_flag && !clear && c_other != MAXV)
        |=> c_other == $past(c_other) + 1'b1);

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> ctr_flat == '0);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && c_dtlb == MAXV) |=> c_dtlb == MAXV);
endmodule

bind stall_charge_counters stall_charge_counters_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rob_full_stall (rob_full_stall),
    .head_dtlb_miss (head_dtlb_miss),
    .head_l2_miss   (head_l2_miss),
    .head_l1_miss   (head_l1_miss),
    .head_long_fu   (head_long_fu),
    .clear          (clear),
    .ctr_flat       (ctr_flat)
);

// File: tb/stall_charge_counters_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks compute expected counter values from the
// requirements and queue them; a monitor pops and compares on each read.
module stall_charge_counters_bench;
    localparam int CW   = 5;
    localparam int MAXV = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rob_full_stall = 1'b0;
    logic          head_dtlb_miss = 1'b0;
    logic          head_l2_miss = 1'b0;
    logic          head_l1_miss = 1'b0;
    logic          head_long_fu = 1'b0;
    logic          clear = 1'b0;
    logic [2:0]    rd_sel = 3'd0;
    logic [CW-1:0] rd_data;

    typedef struct {
        int    sel;
        int    val;
        string tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    event      do_sample;
    int        model [6];
    int        checks = 0;
    int        errors = 0;
    bit        done = 1'b0;

    stall_charge_counters #(.CNT_W(CW)) u_stall_charge_counters (
        .clk            (clk),
        .rst_n          (rst_n),
        .rob_full_stall (rob_full_stall),
        .head_dtlb_miss (head_dtlb_miss),
        .head_l2_miss   (head_l2_miss),
        .head_l1_miss   (head_l1_miss),
        .head_long_fu   (head_long_fu),
        .clear          (clear),
        .rd_sel         (rd_sel),
        .rd_data        (rd_data)
    );

    always #5 clk = ~clk;

    function automatic int sat_inc(int v);
        return (v >= MAXV) ? MAXV : v + 1;
    endfunction

    // Apply one cycle of stimulus and advance the model at the edge.
    task automatic step(bit s, bit d, bit l2, bit l1, bit fu, bit clr);
        rob_full_stall = s;
        head_dtlb_miss = d;
        head_l2_miss   = l2;
        head_l1_miss   = l1;
        head_long_fu   = fu;
        clear          = clr;
        @(posedge clk);
        if (clr) begin
            for (int k = 0; k < 6; k++) model[k] = 0;
        end else begin
            model[0] = sat_inc(model[0]);
            if (s) begin
                if (d)       model[1] = sat_inc(model[1]);
                else if (l2) model[2] = sat_inc(model[2]);
                else if (l1) model[3] = sat_inc(model[3]);
                else if (fu) model[4] = sat_inc(model[4]);
                else         model[5] = sat_inc(model[5]);
            end
        end
        @(negedge clk);
    endtask

    // Select a counter, queue its expected value, trigger the monitor,
    // then spend one idle cycle.
    task automatic read(int sel, string tag);
        exp_item_t it;
        rd_sel = 3'(sel);
        #1;
        it.sel = sel;
        it.val = (sel < 6) ? model[sel] : 0;
        it.tag = tag;
        sb_q.push_back(it);
        -> do_sample;
        #1;
        step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic read_all(string tag);
        for (int k = 0; k < 6; k++) read(k, tag);
    endtask

    // Monitor: pop expected item and compare with the read port.
    initial begin
        forever begin
            @(do_sample);
            if (sb_q.size() != 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                checks++;
                if (int'(rd_data) != it.val) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%0d expected=%0d",
                             it.tag, it.sel, rd_data, it.val);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 6; k++) model[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every counter; R9: unused codes read zero.
        read_all("R1");
        read(6, "R9");
        read(7, "R9");

        // R7: clear to start from a known point.
        step(0, 0, 0, 0, 0, 1);
        read(0, "R7");

        // R3 and R2: flags without a stall charge nothing, total still runs.
        step(0, 1, 1, 1, 1, 0);
        step(0, 1, 0, 0, 0, 0);
        step(0, 0, 0, 1, 1, 0);
        read_all("R3");
        read(0, "R2");

        // R5: priority among simultaneous flags.
        step(1, 1, 1, 1, 1, 0);
        step(1, 1, 0, 1, 0, 0);
        step(1, 0, 1, 1, 1, 0);
        step(1, 0, 0, 1, 1, 0);
        step(1, 0, 0, 0, 1, 0);
        read_all("R5");

        // R6: stall with no flag charges the other bucket.
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);
        read(5, "R6");
        // R4: one cause per stall cycle, seen across all counters.
        read_all("R4");

        // R7: clear wins over a stall in the same cycle.
        step(1, 1, 0, 0, 0, 1);
        read_all("R7");

        // R8: saturation of a cause counter and of the total.
        for (int n = 0; n < MAXV + 4; n++) step(1, 1, 0, 0, 0, 0);
        read(1, "R8");
        read(0, "R8");
        step(1, 0, 1, 0, 0, 0);
        read(1, "R8");
        read(2, "R4");
        read(5, "R3");
        read(7, "R9");

        done = 1'b1;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual=%0d expected=0 pending", sb_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule